// File: doc/BRIEF.md
# I2C Broadcast Software-Reset Detector

This block sits next to the byte engine of an I2C slave and watches the decoded bus traffic for the broadcast software-reset command. The command is the general-call address byte with the write direction (0x00), followed by the command byte 0x06. The byte engine hands over the following:

- bus events: START, repeated START and STOP;
- each received byte, with a flag that marks the address byte;
- the outcome of each acknowledge slot.

For every byte the block accepts, it returns a decision on whether to acknowledge it. When the master closes a correctly acknowledged command with a STOP, the block raises a one-cycle reset pulse toward the register file. The register file then returns to its power-up values, and the slave can be addressed again.

Nothing inside the device can start a reset: only a bus STOP can commit one. A repeated START in place of that STOP cancels the command. A byte that breaks the sequence is refused, which tells the master the command was aborted. Bytes arrive on a valid/ready stream. A byte transfers on a clock edge where both valid and ready are high. The producer must hold the byte and its flag stable until then. Ready drops only during the reset-pulse cycle.

Top module: `swrst_detect`

## Requirements
- R1: After rst_n is released, reset_pulse is 0, ack_valid is 0 and byte_ready is 1.
- R2: In the idle state, an accepted byte flagged as an address is acknowledged (ack_en=1) only when its value is 0x00 (general call, write). Every other value is refused (ack_en=0). The decision appears on ack_valid/ack_en in the cycle after the byte handshake.
- R3: After the general-call address is accepted, the next data byte is acknowledged only when it is 0x06. Any other value is refused, and the sequence is dropped, so a later STOP gives no pulse.
- R4: A STOP that arrives after the acknowledged 0x06 byte raises reset_pulse for exactly one clock cycle, in the cycle after the STOP event.
- R5: A repeated START that arrives after the acknowledged 0x06 byte cancels the command, and a following STOP gives no pulse.
- R6: A further data byte after the 0x06 byte is refused, and the sequence is dropped.
- R7: An acknowledge-slot report with ack_low=0 while the sequence is in progress aborts the sequence.
- R8: byte_ready is 0 during the reset-pulse cycle and 1 again in the cycle after it. A byte held valid meanwhile is taken after the pulse.
- R9: A START or repeated START from any state returns the detector to address matching, and a new sequence can then complete without an intervening STOP.
- R10: reset_pulse never rises unless a STOP event was seen in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | START condition seen (one-cycle strobe) |
| ev_rstart | input | 1 | Repeated START seen (one-cycle strobe) |
| ev_stop | input | 1 | STOP condition seen (one-cycle strobe) |
| byte_valid | input | 1 | Received byte is offered |
| byte_ready | output | 1 | Detector can take a byte |
| byte_data | input | DATA_W | Received byte value |
| byte_is_addr | input | 1 | Byte is the address byte after a (repeated) START |
| ack_slot | input | 1 | Acknowledge slot finished (one-cycle strobe) |
| ack_low | input | 1 | SDA was low in that slot (acknowledged) |
| ack_valid | output | 1 | Acknowledge decision for the last accepted byte |
| ack_en | output | 1 | 1 = drive acknowledge, 0 = leave SDA released |
| reset_pulse | output | 1 | One-cycle reset request to the register file |

## Verification
The bench builds the block with its default parameters: DATA_W=8, general-call code 0x00 and command code 0x06. With these values the byte space is small enough to sweep completely. All 256 address values are offered in the idle state. All 256 data values are offered after an accepted general-call address, each followed by a STOP to see whether a pulse results. Directed sequences then cover the repeated-START cancel, the extra byte, the refused acknowledge slot, the back-pressure during the pulse, and restarting with a START from the middle of a sequence.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GC    = 2'd1,
    ST_CODE  = 2'd2,
    ST_PULSE = 2'd3
  } swrst_state_t;
endpackage

// File: rtl/swrst_byte_match.sv
module swrst_byte_match #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] GC_ADDR  = 8'h00,
  parameter logic [DATA_W-1:0] CMD_CODE = 8'h06
) (
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_is_addr,
  output logic              is_gc_addr,
  output logic              is_cmd
);
  always_comb begin
    is_gc_addr = byte_is_addr && (byte_data == GC_ADDR);
    is_cmd     = !byte_is_addr && (byte_data == CMD_CODE);
  end
endmodule

// File: rtl/swrst_fsm.sv
module swrst_fsm
  import swrst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] GC_ADDR  = 8'h00,
  parameter logic [DATA_W-1:0] CMD_CODE = 8'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_is_addr,
  input  logic              is_gc_addr,
  input  logic              is_cmd,
  input  logic              ack_slot,
  input  logic              ack_low,
  output logic              byte_ready,
  output logic              ack_valid,
  output logic              ack_en,
  output logic              reset_pulse
);
  swrst_state_t state_q, state_d;
  logic byte_fire;
  logic ack_d;

  assign byte_ready  = (state_q != ST_PULSE);
  assign byte_fire   = byte_valid && byte_ready;
  assign reset_pulse = (state_q == ST_PULSE);

  always_comb begin
    state_d = state_q;
    ack_d   = 1'b0;
    if (state_q == ST_PULSE) begin
      state_d = ST_IDLE;
    end else if (ev_stop) begin
      state_d = (state_q == ST_CODE) ? ST_PULSE : ST_IDLE;
    end else if (ev_start || ev_rstart) begin
      state_d = ST_IDLE;
    end else if (ack_slot && !ack_low && state_q != ST_IDLE) begin
      state_d = ST_IDLE;
    end else if (byte_fire) begin
      unique case (state_q)
        ST_IDLE: begin
          if (is_gc_addr) begin
            state_d = ST_GC;
            ack_d   = 1'b1;
          end
        end
        ST_GC: begin
          if (is_cmd) begin
            state_d = ST_CODE;
            ack_d   = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ack_valid <= 1'b0;
      ack_en    <= 1'b0;
    end else begin
      state_q   <= state_d;
      ack_valid <= byte_fire;
      ack_en    <= ack_d;
    end
  end

  // R4: the pulse lasts one cycle
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |=> !reset_pulse);

  // R10: only a bus STOP commits the reset
  a_r10_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_pulse) |-> $past(ev_stop));

  // R5: a repeated START without STOP never leads to a pulse
  a_r5_rstart_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rstart && !ev_stop) |=> !reset_pulse);

  // R2: a decision follows every handshake
  a_r2_decision_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(byte_valid && byte_ready));

  // R3: an acknowledge only for the two sequence bytes
  a_r3_ack_only_match: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_en) |->
      (($past(byte_data) == GC_ADDR && $past(byte_is_addr)) ||
       ($past(byte_data) == CMD_CODE && !$past(byte_is_addr))));

  // R8: nothing is taken in the pulse cycle
  a_r8_no_take_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |=> !ack_valid);
endmodule

// File: rtl/swrst_detect.sv
module swrst_detect #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] GC_ADDR  = 8'h00,
  parameter logic [DATA_W-1:0] CMD_CODE = 8'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_is_addr,
  input  logic              ack_slot,
  input  logic              ack_low,
  output logic              ack_valid,
  output logic              ack_en,
  output logic              reset_pulse
);
  logic is_gc_addr;
  logic is_cmd;

  swrst_byte_match #(
    .DATA_W(DATA_W), .GC_ADDR(GC_ADDR), .CMD_CODE(CMD_CODE)
  ) u_match (
    .byte_data   (byte_data),
    .byte_is_addr(byte_is_addr),
    .is_gc_addr  (is_gc_addr),
    .is_cmd      (is_cmd)
  );

  swrst_fsm #(
    .DATA_W(DATA_W), .GC_ADDR(GC_ADDR), .CMD_CODE(CMD_CODE)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_start    (ev_start),
    .ev_rstart   (ev_rstart),
    .ev_stop     (ev_stop),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .byte_is_addr(byte_is_addr),
    .is_gc_addr  (is_gc_addr),
    .is_cmd      (is_cmd),
    .ack_slot    (ack_slot),
    .ack_low     (ack_low),
    .byte_ready  (byte_ready),
    .ack_valid   (ack_valid),
    .ack_en      (ack_en),
    .reset_pulse (reset_pulse)
  );
endmodule

// File: tb/sim_swrst_detect.sv
module sim_swrst_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 0, ev_rstart = 0, ev_stop = 0;
  logic byte_valid = 0, byte_is_addr = 0;
  logic [7:0] byte_data = 8'h00;
  logic ack_slot = 0, ack_low = 0;
  logic byte_ready, ack_valid, ack_en, reset_pulse;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  swrst_detect u0 (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
    .ev_stop(ev_stop), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .byte_is_addr(byte_is_addr), .ack_slot(ack_slot),
    .ack_low(ack_low), .ack_valid(ack_valid), .ack_en(ack_en),
    .reset_pulse(reset_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe_start(input bit repeated);
    @(negedge clk);
    if (repeated) ev_rstart = 1; else ev_start = 1;
    @(negedge clk);
    ev_start = 0; ev_rstart = 0;
  endtask

  // byte handshake; decision checked in the cycle after
  task automatic send_byte(input logic [7:0] d, input bit is_addr, input bit exp_ack, input string req);
    @(negedge clk);
    byte_valid = 1; byte_data = d; byte_is_addr = is_addr;
    @(negedge clk);
    byte_valid = 0;
    check(ack_valid == 1'b1, req, ack_valid, 1);
    check(ack_en == exp_ack, req, ack_en, exp_ack);
  endtask

  task automatic send_ack_slot(input bit low);
    @(negedge clk);
    ack_slot = 1; ack_low = low;
    @(negedge clk);
    ack_slot = 0; ack_low = 0;
  endtask

  // STOP, then check pulse in the next cycle and its end in the one after
  task automatic send_stop(input bit exp_pulse, input string req);
    @(negedge clk);
    ev_stop = 1;
    @(negedge clk);
    ev_stop = 0;
    check(reset_pulse == exp_pulse, req, reset_pulse, exp_pulse);
    @(negedge clk);
    check(reset_pulse == 1'b0, req, reset_pulse, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(reset_pulse == 0, "R1", reset_pulse, 0);
    check(ack_valid == 0, "R1", ack_valid, 0);
    check(byte_ready == 1, "R1", byte_ready, 1);

    // R2: every address byte in the idle state
    for (int a = 0; a < 256; a++) begin
      strobe_start(0);
      send_byte(a[7:0], 1'b1, a == 0, "R2");
    end
    send_stop(0, "R2");

    // R3/R4: every data byte after the general-call address, then STOP
    for (int d = 0; d < 256; d++) begin
      strobe_start(0);
      send_byte(8'h00, 1'b1, 1'b1, "R3");
      send_ack_slot(1);
      send_byte(d[7:0], 1'b0, d == 6, "R3");
      if (d == 6) send_ack_slot(1);
      send_stop(d == 6, "R4");
    end

    // R5: repeated START cancels, later STOP gives nothing
    strobe_start(0);
    send_byte(8'h00, 1, 1, "R5");
    send_byte(8'h06, 0, 1, "R5");
    strobe_start(1);
    check(reset_pulse == 0, "R5", reset_pulse, 0);
    send_stop(0, "R5");

    // R6: extra byte after the command
    strobe_start(0);
    send_byte(8'h00, 1, 1, "R6");
    send_byte(8'h06, 0, 1, "R6");
    send_byte(8'h06, 0, 0, "R6");
    send_stop(0, "R6");

    // R7: acknowledge slot reported high aborts
    strobe_start(0);
    send_byte(8'h00, 1, 1, "R7");
    send_byte(8'h06, 0, 1, "R7");
    send_ack_slot(0);
    send_stop(0, "R7");

    // R9: START mid-sequence returns to address matching
    strobe_start(0);
    send_byte(8'h00, 1, 1, "R9");
    strobe_start(0);
    send_byte(8'h06, 0, 0, "R9");
    strobe_start(1);
    send_byte(8'h00, 1, 1, "R9");
    send_byte(8'h06, 0, 1, "R9");
    send_stop(1, "R9");

    // R8: back-pressure during the pulse
    strobe_start(0);
    send_byte(8'h00, 1, 1, "R8");
    send_byte(8'h06, 0, 1, "R8");
    @(negedge clk);
    ev_stop = 1;
    @(negedge clk);
    ev_stop = 0;
    byte_valid = 1; byte_data = 8'h00; byte_is_addr = 1;
    check(reset_pulse == 1, "R8", reset_pulse, 1);
    check(byte_ready == 0, "R8", byte_ready, 0);
    @(negedge clk);
    check(ack_valid == 0, "R8", ack_valid, 0);
    check(byte_ready == 1, "R8", byte_ready, 1);
    @(negedge clk);
    byte_valid = 0;
    check(ack_valid == 1, "R8", ack_valid, 1);
    check(ack_en == 1, "R8", ack_en, 1);
    // R10: STOP outside a complete sequence
    send_stop(0, "R10");
    send_stop(0, "R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule